// File: doc/BRIEF.md
# ADC Scan Sequencer

This block runs analog-to-digital conversions from a stored table of scan steps. Each of up to 32 table rows names the channels to convert: a mask of eight direct inputs plus two multiplexed inputs, each with its own 4-bit select and a use flag. A row also carries an optional pre-sample delay drawn from one of four programmable timers, averaging settings and a calibration flag that are passed along with every convert request, and a code for what happens when the row is finished.

An outside state controller starts a scan by presenting enable, trigger and a starting row index. These inputs count only while its unlock input is high. The sequencer then loads rows one at a time. For each channel in a row it raises a convert request towards a conversion engine and holds it until the engine answers with a done strobe. When no channels are left in the row, it follows the row's next-action code. It may stop, move on to the following row, or go back to the starting row and repeat. Rows and timer values are written through a plain synchronous write port.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `conv_req` and `scan_done` are 0.
- R2: While the sequencer is idle, a cycle with `ctl_unlock`=1, `ctl_enable`=1 and `ctl_trigger`=1 starts a scan at row `ctl_entry` (0 to 31). `busy` is 1 on the next cycle and `cur_entry` shows that row.
- R3: While `ctl_unlock`=0, the inputs `ctl_enable`, `ctl_trigger` and `ctl_entry` are ignored. An idle sequencer stays idle and issues no request.
- R4: Within a row, conversions run in ascending direct-channel order first, with `conv_src` equal to the channel number 0 to 7. Then comes the first multiplexed input (`conv_src`=8, `conv_mux_sel`= its select) if its use flag is set. Last comes the second multiplexed input (`conv_src`=9) if its use flag is set.
- R5: `conv_req` stays high until a cycle in which `conv_done` is 1, and falls on the next cycle. Each enabled channel gets exactly one request. `conv_avg_en`, `conv_avg_cnt` and `conv_cal` carry the row's averaging and calibration fields during the request.
- R6: When a row's delay flag is set, each of its requests rises N+1 cycles later than it would with the flag clear. N (0 to 1023) is the value of the timer named by the row's 2-bit timer select.
- R7: Next-action code 0 (and the unused code 3) ends the scan. `busy` falls, and `scan_done` is high for exactly that one cycle.
- R8: Next-action code 1 moves to the following row. Row 31 is followed by row 0.
- R9: Next-action code 2 goes back to the scan's starting row. The scan repeats until it is stopped.
- R10: A cycle with `ctl_unlock`=1 and `ctl_enable`=0 during a scan returns the sequencer to idle on the next cycle. It drops `conv_req` and gives no `scan_done` pulse.
- R11: A start request made while a scan is running is ignored. The running scan, its row order and `cur_entry` are unaffected.
- R12: A row with an empty mask and both use flags clear issues no request and goes straight to its next action.
- R13: The table word is laid out as follows. Bits [7:0] hold the direct mask (bit i = channel i). Bits [11:8] hold the first mux select and [15:12] the second mux select. Bit 16 is the first mux use flag and bit 17 the second. Bit 18 is the delay flag and [20:19] the timer select. Bit 21 is the averaging enable and [24:22] the averaging count. Bit 25 is the calibration flag and [27:26] the next action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table row write strobe |
| tbl_waddr | input | 5 | Row index to write |
| tbl_wdata | input | 28 | Row contents, layout per R13 |
| tmr_we | input | 1 | Sample timer write strobe |
| tmr_waddr | input | 2 | Timer index to write |
| tmr_wdata | input | 10 | Timer value N (delay N+1 cycles) |
| ctl_unlock | input | 1 | Start-control qualifier |
| ctl_enable | input | 1 | Sequencer enable |
| ctl_trigger | input | 1 | Scan start request |
| ctl_entry | input | 5 | Starting row index |
| conv_req | output | 1 | Convert request, held until done |
| conv_src | output | 4 | Source: 0-7 direct, 8 first mux, 9 second mux |
| conv_mux_sel | output | 4 | Mux channel select for sources 8 and 9 |
| conv_avg_en | output | 1 | Averaging enable of the current row |
| conv_avg_cnt | output | 3 | Averaging count of the current row |
| conv_cal | output | 1 | Calibration request of the current row |
| conv_done | input | 1 | Conversion finished strobe |
| busy | output | 1 | Scan in progress |
| cur_entry | output | 5 | Row being processed |
| scan_done | output | 1 | One-cycle pulse when a scan stops normally |

## Verification
A corrupted pending-channel set or a wrong priority pick shows up at once as a wrong `conv_src` sequence. The error appears on the very next request after the row loads. A wrong row pointer after a next action shows within one row as the wrong channel list, or as a scan that never stops. Timer or delay-state faults show as a request rising earlier or later than the exact N+1 cycle offset, so request timing is compared cycle-for-cycle against a delay-free row. Faults in the start and abort gating show as `busy` changing, or failing to change, on the cycle after the control inputs.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  parameter int DIRECT_CH  = 8;
  parameter int MUXSEL_W   = 4;
  parameter int AVGCNT_W   = 3;
  parameter int NUM_TIMERS = 4;
  parameter int ACT_W      = 2;

  localparam int TSEL_W = $clog2(NUM_TIMERS);
  localparam int PEND_W = DIRECT_CH + 2;
  localparam int SRC_W  = $clog2(PEND_W);

  typedef enum logic [ACT_W-1:0] {
    ACT_STOP   = 2'd0,
    ACT_NEXT   = 2'd1,
    ACT_REPEAT = 2'd2,
    ACT_RSVD   = 2'd3
  } act_e;

  typedef struct packed {
    act_e                act;
    logic                cal;
    logic [AVGCNT_W-1:0] avg_cnt;
    logic                avg_en;
    logic [TSEL_W-1:0]   tsel;
    logic                dly_en;
    logic                mux1_use;
    logic                mux0_use;
    logic [MUXSEL_W-1:0] mux1_sel;
    logic [MUXSEL_W-1:0] mux0_sel;
    logic [DIRECT_CH-1:0] dmask;
  } row_t;

  localparam int ROW_W = $bits(row_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PICK,
    ST_DELAY,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/seq_row_ram.sv
`timescale 1ns/1ps
module seq_row_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 28,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_sample_timer.sv
`timescale 1ns/1ps
module seq_sample_timer
  import adc_seq_pkg::*;
#(
  parameter int TMR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TSEL_W-1:0] wr_sel,
  input  logic [TMR_W-1:0]  wr_val,
  input  logic              start,
  input  logic [TSEL_W-1:0] start_sel,
  input  logic              clear,
  output logic              expired
);
  logic [TMR_W-1:0] preset [NUM_TIMERS];
  logic [TMR_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TIMERS; i++) preset[i] <= '0;
    end else if (wr_en) begin
      preset[wr_sel] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (clear) begin
      run <= 1'b0;
    end else if (start) begin
      cnt <= preset[start_sel];
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - TMR_W'(1);
    end
  end

  assign expired = run && (cnt == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    run && (cnt != '0) && !clear && !start |=> run && (cnt == $past(cnt) - TMR_W'(1))); // R6
  AST_TMR_STOP: assert property (@(posedge clk) disable iff (rst)
    expired && !start |=> !run); // R6
endmodule

// File: rtl/seq_chan_pick.sv
`timescale 1ns/1ps
module seq_chan_pick
  import adc_seq_pkg::*;
(
  input  logic [PEND_W-1:0] pend,
  output logic              any,
  output logic [PEND_W-1:0] grant,
  output logic [SRC_W-1:0]  idx
);
  logic [PEND_W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < PEND_W; i++) begin : g_prio
    assign seen[i+1] = seen[i] | pend[i];
    assign grant[i]  = pend[i] & ~seen[i];
  end

  assign any = seen[PEND_W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < PEND_W; i++) begin
      if (grant[i]) idx = idx | SRC_W'(i);
    end
  end
endmodule

// File: rtl/adc_scan_sequencer.sv
`timescale 1ns/1ps
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TMR_W = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tbl_we,
  input  logic [AW-1:0]       tbl_waddr,
  input  logic [ROW_W-1:0]    tbl_wdata,
  input  logic                tmr_we,
  input  logic [TSEL_W-1:0]   tmr_waddr,
  input  logic [TMR_W-1:0]    tmr_wdata,
  input  logic                ctl_unlock,
  input  logic                ctl_enable,
  input  logic                ctl_trigger,
  input  logic [AW-1:0]       ctl_entry,
  output logic                conv_req,
  output logic [SRC_W-1:0]    conv_src,
  output logic [MUXSEL_W-1:0] conv_mux_sel,
  output logic                conv_avg_en,
  output logic [AVGCNT_W-1:0] conv_avg_cnt,
  output logic                conv_cal,
  input  logic                conv_done,
  output logic                busy,
  output logic [AW-1:0]       cur_entry,
  output logic                scan_done
);
  localparam logic [SRC_W-1:0] SRC_MUX0 = SRC_W'(DIRECT_CH);
  localparam logic [SRC_W-1:0] SRC_MUX1 = SRC_W'(DIRECT_CH + 1);
  localparam logic [AW-1:0]    LAST_ROW = AW'(DEPTH - 1);

  seq_state_e          state;
  logic [PEND_W-1:0]   pend;
  logic [AW-1:0]       home_q;
  logic [MUXSEL_W-1:0] r_mux0_sel, r_mux1_sel;
  logic                r_dly_en, r_avg_en, r_cal;
  logic [TSEL_W-1:0]   r_tsel;
  logic [AVGCNT_W-1:0] r_avg_cnt;
  act_e                r_act;

  logic [ROW_W-1:0]    rd_word;
  row_t                rd_row;
  logic                rd_en;
  logic [AW-1:0]       rd_addr;
  logic [AW-1:0]       next_row;

  logic                pick_any;
  logic [PEND_W-1:0]   pick_grant;
  logic [SRC_W-1:0]    pick_idx;

  logic                start_ok, abort, tmr_start, tmr_expired, row_empty;

  assign rd_row    = row_t'(rd_word);
  assign start_ok  = ctl_unlock && ctl_enable && ctl_trigger && (state == ST_IDLE);
  assign abort     = ctl_unlock && !ctl_enable && (state != ST_IDLE);
  assign row_empty = (state == ST_PICK) && !pick_any;
  assign tmr_start = (state == ST_PICK) && pick_any && r_dly_en && !abort;

  always_comb begin
    next_row = (cur_entry == LAST_ROW) ? '0 : cur_entry + AW'(1);
    if (r_act == ACT_REPEAT) next_row = home_q;
  end

  always_comb begin
    rd_en   = start_ok || (row_empty && (r_act == ACT_NEXT || r_act == ACT_REPEAT));
    rd_addr = start_ok ? ctl_entry : next_row;
  end

  seq_row_ram #(.DEPTH(DEPTH), .WIDTH(ROW_W)) u_rows (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  seq_sample_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (tmr_we),
    .wr_sel    (tmr_waddr),
    .wr_val    (tmr_wdata),
    .start     (tmr_start),
    .start_sel (r_tsel),
    .clear     (abort),
    .expired   (tmr_expired)
  );

  seq_chan_pick u_pick (
    .pend  (pend),
    .any   (pick_any),
    .grant (pick_grant),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      busy         <= 1'b0;
      scan_done    <= 1'b0;
      conv_req     <= 1'b0;
      conv_src     <= '0;
      conv_mux_sel <= '0;
      conv_avg_en  <= 1'b0;
      conv_avg_cnt <= '0;
      conv_cal     <= 1'b0;
      pend         <= '0;
      cur_entry    <= '0;
      home_q       <= '0;
      r_mux0_sel   <= '0;
      r_mux1_sel   <= '0;
      r_dly_en     <= 1'b0;
      r_tsel       <= '0;
      r_avg_en     <= 1'b0;
      r_avg_cnt    <= '0;
      r_cal        <= 1'b0;
      r_act        <= ACT_STOP;
    end else begin
      scan_done <= 1'b0;
      if (abort) begin
        state    <= ST_IDLE;
        busy     <= 1'b0;
        conv_req <= 1'b0;
        pend     <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start_ok) begin
              state     <= ST_LOAD;
              busy      <= 1'b1;
              cur_entry <= ctl_entry;
              home_q    <= ctl_entry;
            end
          end
          ST_LOAD: begin
            pend       <= {rd_row.mux1_use, rd_row.mux0_use, rd_row.dmask};
            r_mux0_sel <= rd_row.mux0_sel;
            r_mux1_sel <= rd_row.mux1_sel;
            r_dly_en   <= rd_row.dly_en;
            r_tsel     <= rd_row.tsel;
            r_avg_en   <= rd_row.avg_en;
            r_avg_cnt  <= rd_row.avg_cnt;
            r_cal      <= rd_row.cal;
            r_act      <= rd_row.act;
            state      <= ST_PICK;
          end
          ST_PICK: begin
            if (pick_any) begin
              conv_src     <= pick_idx;
              conv_mux_sel <= (pick_idx == SRC_MUX1) ? r_mux1_sel :
                              (pick_idx == SRC_MUX0) ? r_mux0_sel : '0;
              conv_avg_en  <= r_avg_en;
              conv_avg_cnt <= r_avg_cnt;
              conv_cal     <= r_cal;
              if (r_dly_en) begin
                state <= ST_DELAY;
              end else begin
                conv_req <= 1'b1;
                state    <= ST_WAIT;
              end
            end else begin
              case (r_act)
                ACT_NEXT, ACT_REPEAT: begin
                  cur_entry <= next_row;
                  state     <= ST_LOAD;
                end
                default: begin
                  state     <= ST_IDLE;
                  busy      <= 1'b0;
                  scan_done <= 1'b1;
                end
              endcase
            end
          end
          ST_DELAY: begin
            if (tmr_expired) begin
              conv_req <= 1'b1;
              state    <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (conv_done) begin
              conv_req <= 1'b0;
              pend     <= pend & ~pick_grant;
              state    <= ST_PICK;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_done && !(ctl_unlock && !ctl_enable) |=> conv_req); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    conv_req && conv_done |=> !conv_req); // R5
  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (conv_src <= SRC_MUX1)); // R4
  AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy && !ctl_unlock |=> !busy); // R3
  AST_START_ROW: assert property (@(posedge clk) disable iff (rst)
    !busy && ctl_unlock && ctl_enable && ctl_trigger |=> busy && (cur_entry == $past(ctl_entry))); // R2
  AST_HOME_KEPT: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(home_q))); // R11
  AST_DONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> !busy && $past(busy)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    busy && ctl_unlock && !ctl_enable |=> !busy && !conv_req && !scan_done); // R10
endmodule

// File: tb/test_adc_scan_sequencer.sv
`timescale 1ns/1ps
module test_adc_scan_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_waddr = '0;
  logic [27:0] tbl_wdata = '0;
  logic        tmr_we = 1'b0;
  logic [1:0]  tmr_waddr = '0;
  logic [9:0]  tmr_wdata = '0;
  logic        ctl_unlock = 1'b0, ctl_enable = 1'b0, ctl_trigger = 1'b0;
  logic [4:0]  ctl_entry = '0;
  logic        conv_req, conv_avg_en, conv_cal, busy, scan_done;
  logic [3:0]  conv_src, conv_mux_sel;
  logic [2:0]  conv_avg_cnt;
  logic [4:0]  cur_entry;
  logic        conv_done = 1'b0;

  int vectors = 0;
  int fails   = 0;
  int log_n   = 0;
  int done_cnt = 0;
  int lat_cnt = 0;
  int log_src [64];
  int log_mux [64];
  int log_avg [64];
  int log_cal [64];

  always #10 clk = ~clk;

  adc_scan_sequencer i_adc_scan_sequencer (
    .clk(clk), .rst(rst),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .tmr_we(tmr_we), .tmr_waddr(tmr_waddr), .tmr_wdata(tmr_wdata),
    .ctl_unlock(ctl_unlock), .ctl_enable(ctl_enable), .ctl_trigger(ctl_trigger),
    .ctl_entry(ctl_entry),
    .conv_req(conv_req), .conv_src(conv_src), .conv_mux_sel(conv_mux_sel),
    .conv_avg_en(conv_avg_en), .conv_avg_cnt(conv_avg_cnt), .conv_cal(conv_cal),
    .conv_done(conv_done),
    .busy(busy), .cur_entry(cur_entry), .scan_done(scan_done)
  );

  // Conversion engine model: answers each request after a short latency.
  always @(negedge clk) begin
    if (scan_done) done_cnt++;
    if (conv_done) begin
      conv_done = 1'b0;
      lat_cnt = 0;
    end else if (conv_req) begin
      if (lat_cnt == 2) begin
        conv_done = 1'b1;
        if (log_n < 64) begin
          log_src[log_n] = int'(conv_src);
          log_mux[log_n] = int'(conv_mux_sel);
          log_avg[log_n] = int'({conv_avg_en, conv_avg_cnt});
          log_cal[log_n] = int'(conv_cal);
        end
        log_n++;
        lat_cnt = 0;
      end else begin
        lat_cnt++;
      end
    end else begin
      lat_cnt = 0;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // R13 row word layout
  function automatic logic [27:0] mk_row(input logic [7:0] mask,
      input logic m0u, input logic [3:0] m0, input logic m1u, input logic [3:0] m1,
      input logic dly, input logic [1:0] ts, input logic ae, input logic [2:0] ac,
      input logic cal, input logic [1:0] act);
    return {act, cal, ac, ae, ts, dly, m1u, m0u, m1, m0, mask};
  endfunction

  task automatic wr_row(input int idx, input logic [27:0] w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 5'(idx); tbl_wdata = w;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wr_tmr(input int sel, input int val);
    @(negedge clk);
    tmr_we = 1'b1; tmr_waddr = 2'(sel); tmr_wdata = 10'(val);
    @(negedge clk);
    tmr_we = 1'b0;
  endtask

  task automatic start_scan(input int idx);
    @(negedge clk);
    ctl_unlock = 1'b1; ctl_enable = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'(idx);
    @(negedge clk);
    ctl_trigger = 1'b0; ctl_unlock = 1'b0;
  endtask

  task automatic wait_idle(output int saw_done);
    int guard = 0;
    saw_done = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    saw_done = int'(scan_done);
    chk("R7 scan end reached", int'(busy), 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 req in reset", int'(conv_req), 0);
    chk("R1 done in reset", int'(scan_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 req after reset", int'(conv_req), 0);
  endtask

  task automatic t_locked();
    log_n = 0;
    @(negedge clk);
    ctl_unlock = 1'b0; ctl_enable = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'd5;
    repeat (4) @(negedge clk);
    chk("R3 locked busy", int'(busy), 0);
    chk("R3 locked req", int'(conv_req), 0);
    ctl_trigger = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 locked no conversions", log_n, 0);
  endtask

  task automatic t_order();
    int sd;
    int exp_src [5] = '{2, 5, 7, 8, 9};
    int d0;
    log_n = 0;
    d0 = done_cnt;
    start_scan(5);
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 start row", int'(cur_entry), 5);
    wait_idle(sd);
    chk("R7 done pulse at end", sd, 1);
    @(negedge clk);
    chk("R7 done one cycle", int'(scan_done), 0);
    chk("R7 single done", done_cnt - d0, 1);
    chk("R4 conversion count", log_n, 5);
    for (int i = 0; i < 5; i++) chk("R4 source order", log_src[i], exp_src[i]);
    chk("R13 mux0 select", log_mux[3], 11);
    chk("R13 mux1 select", log_mux[4], 6);
    chk("R4 direct mux sel zero", log_mux[0], 0);
    chk("R5 avg fields", log_avg[2], 8 + 5);
    chk("R5 cal flag", log_cal[4], 1);
    // reserved code 3 stops like code 0
    log_n = 0;
    start_scan(25);
    wait_idle(sd);
    chk("R7 code3 stops with done", sd, 1);
    chk("R7 code3 one conversion", log_n, 1);
  endtask

  task automatic t_advance();
    int sd;
    log_n = 0;
    start_scan(30);
    wait_idle(sd);
    chk("R8 conversions across rows", log_n, 3);
    chk("R8 row30 ch", log_src[0], 1);
    chk("R8 row31 ch", log_src[1], 3);
    chk("R8 wrap to row0 ch", log_src[2], 4);
    chk("R8 ends on row0", int'(cur_entry), 0);
  endtask

  task automatic t_empty();
    int sd;
    log_n = 0;
    start_scan(10);
    wait_idle(sd);
    chk("R12 empty row skipped", log_n, 1);
    chk("R12 next row channel", log_src[0], 6);
    log_n = 0;
    start_scan(12);
    wait_idle(sd);
    chk("R12 lone empty row done", sd, 1);
    chk("R12 lone empty no conversion", log_n, 0);
  endtask

  task automatic measure(input int idx, output int n);
    int sd;
    n = 0;
    start_scan(idx);
    while (!conv_req && n < 3000) begin
      @(negedge clk);
      n++;
    end
    wait_idle(sd);
  endtask

  task automatic t_delay();
    int n0, n1, n2;
    measure(14, n0);
    measure(15, n1);
    measure(16, n2);
    chk("R6 timer0 N=5 extra cycles", n1 - n0, 6);
    chk("R6 timer2 N=20 extra cycles", n2 - n0, 21);
  endtask

  task automatic t_busy_trigger();
    int sd;
    log_n = 0;
    start_scan(20);
    repeat (3) @(negedge clk);
    ctl_unlock = 1'b1; ctl_enable = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'd5;
    @(negedge clk);
    ctl_trigger = 1'b0; ctl_unlock = 1'b0;
    chk("R11 row unchanged", int'(cur_entry), 20);
    wait_idle(sd);
    chk("R11 conversion count", log_n, 4);
    for (int i = 0; i < 4; i++) chk("R11 order kept", log_src[i], i);
  endtask

  task automatic t_repeat_abort();
    int guard = 0;
    int d0;
    int exp_src [5] = '{1, 2, 1, 2, 1};
    log_n = 0;
    start_scan(22);
    while (log_n < 5 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    for (int i = 0; i < 5; i++) chk("R9 repeat sequence", log_src[i], exp_src[i]);
    chk("R9 still busy", int'(busy), 1);
    d0 = done_cnt;
    ctl_unlock = 1'b1; ctl_enable = 1'b0;
    @(negedge clk);
    ctl_unlock = 1'b0; ctl_enable = 1'b1;
    chk("R10 busy dropped", int'(busy), 0);
    chk("R10 request dropped", int'(conv_req), 0);
    repeat (5) @(negedge clk);
    chk("R10 no done pulse", done_cnt - d0, 0);
    chk("R10 stays idle", int'(busy), 0);
  endtask

  initial begin
    t_reset();
    wr_row(5,  mk_row(8'b1010_0100, 1'b1, 4'd11, 1'b1, 4'd6, 1'b0, 2'd0, 1'b1, 3'd5, 1'b1, 2'd0));
    wr_row(25, mk_row(8'b0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd3));
    wr_row(30, mk_row(8'b0000_0010, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd1));
    wr_row(31, mk_row(8'b0000_1000, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd1));
    wr_row(0,  mk_row(8'b0001_0000, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(10, mk_row(8'b0000_0000, 1'b0, 4'd3, 1'b0, 4'd4, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd1));
    wr_row(11, mk_row(8'b0100_0000, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(12, mk_row(8'b0000_0000, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(14, mk_row(8'b0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(15, mk_row(8'b0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 2'd0, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(16, mk_row(8'b0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 2'd2, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(20, mk_row(8'b0000_1111, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd0));
    wr_row(22, mk_row(8'b0000_0010, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd1));
    wr_row(23, mk_row(8'b0000_0100, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 2'd2));
    wr_tmr(0, 5);
    wr_tmr(1, 1000);
    wr_tmr(2, 20);
    t_locked();
    t_order();
    t_advance();
    t_empty();
    t_delay();
    t_busy_trigger();
    t_repeat_abort();
    summary();
    $finish;
  end
endmodule